// File: doc/BRIEF.md
# Inset Window Display Timing with Border

This block drives the display side of a picture-in-picture path. It counts read-clock periods from the parent horizontal sync and lines from the parent vertical sync, and from those counts it finds the region of the current pixel: outside, border, or inset picture. Inside the picture it issues one memory read strobe per pixel, together with the index of the stored line being read. Around the picture it raises a border flag and presents the programmed border colour, widened to six bits per component. A fast-switch select, high over both picture and border, leaves through a programmable delay line so that it lines up with the picture data at the chip output.

The read clock is a clock enable (`rd_ce`) on the system clock. All counting happens only on enabled cycles, and the syncs count only when they arrive on one. The geometry inputs (positions, border widths, line doubling, size factor and line standard) are copied into shadow registers on each vertical sync, so the window moves only at a field boundary. The border colour and select delay are used live. The picture data is taken to trail the read strobe by 8 read periods, and that is where the select lines up when the signed delay is zero.

Two state machines set the regions. The horizontal machine has the states H_PRE, H_LBRD, H_PIC, H_RBRD and H_POST. Hsync forces H_PRE. H_PRE goes to H_LBRD at the left border start, or straight to H_PIC when the width is zero. H_LBRD goes to H_PIC at the picture start. H_PIC goes to H_RBRD at the picture end, or to H_POST when the width is zero. H_RBRD goes to H_POST at the border end. The vertical machine has V_PRE, V_TOPB, V_PIC, V_BOTB and V_POST, with the same transitions counted in lines. Vsync forces V_PRE.

Top module: `pip_overlay_timing`

## Requirements
- R1: After reset `pix_rd`, `border_flag` and `sel_out` are low and `rd_line` is 0.
- R2: Column c is the number of enabled cycles after the enabled cycle that carried hsync, counting from 0. On picture lines, `pix_rd` is high exactly in columns 54+hpos up to 54+hpos+W-1. W is 212 when `quarter`=0 and 160 when `quarter`=1.
- R3: Line n is the number of hsyncs after the vsync cycle, the vsync line being line 0. Picture lines run from 4+vpos for Hd lines. The base height is 88 (quarter=0, std625=1), 76 (quarter=0, std625=0), 66 (quarter=1, std625=1) or 57 (quarter=1, std625=0). Hd is the base height, doubled when doubling is on.
- R4: On picture lines, `border_flag` is high in the `hbw` columns directly left and right of the picture. When `hbw`=0 there is no side border.
- R5: `border_flag` is high on the `vbw` lines directly above and below the picture, across the picture columns and the side border columns. When `vbw`=0 there is no top or bottom border.
- R6: `bdr_y`, `bdr_u` and `bdr_v` equal `bcolor[11:8]`, `bcolor[7:4]` and `bcolor[3:0]` respectively, each followed by two zero bits.
- R7: With `dbl_en`=1 each stored line is read on two consecutive display lines, so `rd_line` = (n-(4+vpos))/2 on picture lines.
- R8: With `dbl_en`=0, `rd_line` = n-(4+vpos) on picture lines.
- R9: On enabled cycles `sel_out` equals (picture or border) as it stood 8+`sel_dly` enabled cycles earlier. `sel_dly` is signed two's complement from -8 to +7.
- R10: Changes to hpos, vpos, hbw, vbw, dbl_en, quarter or std625 between vsyncs do not move the window until the next vsync.
- R11: Counters and states advance only on enabled cycles, and `pix_rd` is low whenever `rd_ce` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_ce | input | 1 | Read-pixel clock enable |
| hsync | input | 1 | Parent line sync strobe, used with rd_ce |
| vsync | input | 1 | Parent field sync strobe, used with rd_ce |
| hpos | input | 10 | Horizontal picture offset in pixels |
| vpos | input | 8 | Vertical picture offset in lines |
| hbw | input | 3 | Side border width in pixels |
| vbw | input | 2 | Top/bottom border width in lines |
| bcolor | input | 12 | Border colour: Y [11:8], B-Y [7:4], R-Y [3:0] |
| dbl_en | input | 1 | Read each stored line twice |
| quarter | input | 1 | 0: one-ninth picture, 1: one-sixteenth picture |
| std625 | input | 1 | 1: 625-line inset, 0: 525-line inset |
| sel_dly | input | 4 | Signed select delay |
| pix_rd | output | 1 | Memory pixel read strobe |
| rd_line | output | 7 | Stored line index being read |
| border_flag | output | 1 | Current pixel lies in the border |
| bdr_y | output | 6 | Border luminance |
| bdr_u | output | 6 | Border B-Y component |
| bdr_v | output | 6 | Border R-Y component |
| sel_out | output | 1 | Delayed fast-switch select |

## Verification
The geometry shadow load and the line restart fall in the same cycle, because vsync always arrives on the same enabled cycle as an hsync. That cycle must still use the old geometry while it resets both machines. The bench provokes this by changing positions and widths right after a field's vsync line, using values from `$urandom` with a fixed seed together with directed extremes. It then judges every enabled cycle against a model that captures geometry only at the vsync cycle. The select-delay taps cross these field boundaries too, and are judged against a history of the expected select.

// File: rtl/pip_pkg.sv
package pip_pkg;
    typedef enum logic [2:0] {
        H_PRE  = 3'd0,
        H_LBRD = 3'd1,
        H_PIC  = 3'd2,
        H_RBRD = 3'd3,
        H_POST = 3'd4
    } hstate_t;

    typedef enum logic [2:0] {
        V_PRE  = 3'd0,
        V_TOPB = 3'd1,
        V_PIC  = 3'd2,
        V_BOTB = 3'd3,
        V_POST = 3'd4
    } vstate_t;
endpackage

// File: rtl/pip_hscan.sv
module pip_hscan
    import pip_pkg::*;
#(
    parameter int CNT_W = 11,
    parameter int BW_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             hsync,
    input  logic [CNT_W-1:0] pic_start,
    input  logic [CNT_W-1:0] pic_len,
    input  logic [BW_W-1:0]  bw,
    output logic             in_pic,
    output logic             in_side
);
    hstate_t          state, nxt;
    logic [CNT_W-1:0] hcnt, hcnt_next;
    logic [CNT_W-1:0] lb_start, pic_end, rb_end;

    assign lb_start  = pic_start - CNT_W'(bw);
    assign pic_end   = pic_start + pic_len;
    assign rb_end    = pic_end + CNT_W'(bw);
    assign hcnt_next = (&hcnt) ? hcnt : hcnt + 1'b1;

    always_comb begin
        nxt = state;
        unique case (state)
            H_PRE: begin
                if (hcnt_next >= pic_start)
                    nxt = H_PIC;
                else if (bw != '0 && hcnt_next >= lb_start)
                    nxt = H_LBRD;
            end
            H_LBRD: if (hcnt_next >= pic_start) nxt = H_PIC;
            H_PIC: begin
                if (hcnt_next >= rb_end)
                    nxt = H_POST;
                else if (hcnt_next >= pic_end)
                    nxt = H_RBRD;
            end
            H_RBRD: if (hcnt_next >= rb_end) nxt = H_POST;
            H_POST: nxt = H_POST;
            default: nxt = H_PRE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= H_PRE;
            hcnt  <= '0;
        end else if (ce) begin
            if (hsync) begin
                state <= H_PRE;
                hcnt  <= '0;
            end else begin
                state <= nxt;
                hcnt  <= hcnt_next;
            end
        end
    end

    always_comb begin
        in_pic  = (state == H_PIC);
        in_side = (state == H_LBRD) || (state == H_RBRD);
    end

    assert_hsync_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && hsync) |=> (state == H_PRE && hcnt == '0));

    assert_hold_without_ce_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce) |=> ($stable(hcnt) && $stable(state)));
endmodule

// File: rtl/pip_vscan.sv
module pip_vscan
    import pip_pkg::*;
#(
    parameter int CNT_W  = 9,
    parameter int BW_W   = 2,
    parameter int LINE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              hsync,
    input  logic              vsync,
    input  logic              dbl,
    input  logic [CNT_W-1:0]  pic_start,
    input  logic [CNT_W-1:0]  pic_len,
    input  logic [BW_W-1:0]   bw,
    output logic              in_pic,
    output logic              in_band,
    output logic [LINE_W-1:0] line_idx
);
    vstate_t          state, nxt;
    logic [CNT_W-1:0] vcnt, vcnt_next;
    logic [CNT_W-1:0] tb_start, pic_end, bb_end;
    logic             phase;
    logic             advance;

    assign tb_start  = pic_start - CNT_W'(bw);
    assign pic_end   = pic_start + pic_len;
    assign bb_end    = pic_end + CNT_W'(bw);
    assign vcnt_next = (&vcnt) ? vcnt : vcnt + 1'b1;
    assign advance   = ce && hsync && !vsync;

    always_comb begin
        nxt = state;
        unique case (state)
            V_PRE: begin
                if (vcnt_next >= pic_start)
                    nxt = V_PIC;
                else if (bw != '0 && vcnt_next >= tb_start)
                    nxt = V_TOPB;
            end
            V_TOPB: if (vcnt_next >= pic_start) nxt = V_PIC;
            V_PIC: begin
                if (vcnt_next >= bb_end)
                    nxt = V_POST;
                else if (vcnt_next >= pic_end)
                    nxt = V_BOTB;
            end
            V_BOTB: if (vcnt_next >= bb_end) nxt = V_POST;
            V_POST: nxt = V_POST;
            default: nxt = V_PRE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= V_PRE;
            vcnt     <= '0;
            phase    <= 1'b0;
            line_idx <= '0;
        end else if (ce && vsync) begin
            state    <= V_PRE;
            vcnt     <= '0;
            phase    <= 1'b0;
            line_idx <= '0;
        end else if (advance) begin
            state <= nxt;
            vcnt  <= vcnt_next;
            if (nxt == V_PIC && state != V_PIC) begin
                phase    <= 1'b0;
                line_idx <= '0;
            end else if (state == V_PIC) begin
                if (dbl && !phase) begin
                    phase <= 1'b1;
                end else begin
                    phase    <= 1'b0;
                    line_idx <= line_idx + 1'b1;
                end
            end
        end
    end

    always_comb begin
        in_pic  = (state == V_PIC);
        in_band = (state == V_TOPB) || (state == V_BOTB);
    end

    assert_vsync_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && vsync) |=> (state == V_PRE && vcnt == '0));

    assert_line_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == V_PIC && $past(state) == V_PIC && line_idx != $past(line_idx))
        |-> (line_idx == $past(line_idx) + 1'b1));
endmodule

// File: rtl/pip_seldelay.sv
module pip_seldelay #(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             raw,
    input  logic [DLY_W-1:0] dly,
    output logic             sel
);
    localparam int DEPTH = 2 ** DLY_W;
    localparam int BASE  = 2 ** (DLY_W - 1);

    logic [DEPTH-2:0] hist;
    logic [DEPTH-1:0] taps;
    logic [DLY_W-1:0] idx;

    assign taps = {hist, raw};
    assign idx  = dly + DLY_W'(BASE);
    assign sel  = taps[idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hist <= '0;
        else if (ce)
            hist <= {hist[DEPTH-3:0], raw};
    end
endmodule

// File: rtl/pip_overlay_timing.sv
module pip_overlay_timing #(
    parameter int HPOS_W  = 10,
    parameter int VPOS_W  = 8,
    parameter int HBW_W   = 3,
    parameter int VBW_W   = 2,
    parameter int COMP_W  = 4,
    parameter int PAD_W   = 2,
    parameter int DLY_W   = 4,
    parameter int HOFF    = 54,
    parameter int VOFF    = 4,
    parameter int WIDE    = 212,
    parameter int NARROW  = 160,
    parameter int H3_625  = 88,
    parameter int H3_525  = 76,
    parameter int H4_625  = 66,
    parameter int H4_525  = 57
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_ce,
    input  logic                        hsync,
    input  logic                        vsync,
    input  logic [HPOS_W-1:0]           hpos,
    input  logic [VPOS_W-1:0]           vpos,
    input  logic [HBW_W-1:0]            hbw,
    input  logic [VBW_W-1:0]            vbw,
    input  logic [3*COMP_W-1:0]         bcolor,
    input  logic                        dbl_en,
    input  logic                        quarter,
    input  logic                        std625,
    input  logic [DLY_W-1:0]            sel_dly,
    output logic                        pix_rd,
    output logic [$clog2(H3_625+1)-1:0] rd_line,
    output logic                        border_flag,
    output logic [COMP_W+PAD_W-1:0]     bdr_y,
    output logic [COMP_W+PAD_W-1:0]     bdr_u,
    output logic [COMP_W+PAD_W-1:0]     bdr_v,
    output logic                        sel_out
);
    localparam int LINE_W = $clog2(H3_625 + 1);
    localparam int HCNT_W = $clog2(HOFF + 2**HPOS_W + WIDE + 2**HBW_W + 1);
    localparam int VCNT_W = $clog2(VOFF + 2**VPOS_W + 2*H3_625 + 2*(2**VBW_W) + 1);

    logic [HPOS_W-1:0] sh_hpos;
    logic [VPOS_W-1:0] sh_vpos;
    logic [HBW_W-1:0]  sh_hbw;
    logic [VBW_W-1:0]  sh_vbw;
    logic              sh_dbl, sh_quarter, sh_std625;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_hpos    <= '0;
            sh_vpos    <= '0;
            sh_hbw     <= '0;
            sh_vbw     <= '0;
            sh_dbl     <= 1'b0;
            sh_quarter <= 1'b0;
            sh_std625  <= 1'b0;
        end else if (rd_ce && vsync) begin
            sh_hpos    <= hpos;
            sh_vpos    <= vpos;
            sh_hbw     <= hbw;
            sh_vbw     <= vbw;
            sh_dbl     <= dbl_en;
            sh_quarter <= quarter;
            sh_std625  <= std625;
        end
    end

    logic [HCNT_W-1:0] h_start, h_len;
    logic [VCNT_W-1:0] v_start, v_base, v_len;

    always_comb begin
        h_start = HCNT_W'(HOFF) + HCNT_W'(sh_hpos);
        h_len   = sh_quarter ? HCNT_W'(NARROW) : HCNT_W'(WIDE);
        v_start = VCNT_W'(VOFF) + VCNT_W'(sh_vpos);
        if (sh_quarter)
            v_base = sh_std625 ? VCNT_W'(H4_625) : VCNT_W'(H4_525);
        else
            v_base = sh_std625 ? VCNT_W'(H3_625) : VCNT_W'(H3_525);
        v_len = sh_dbl ? (v_base << 1) : v_base;
    end

    logic h_pic, h_side, v_pic, v_band;
    logic pic, bord;

    pip_hscan #(.CNT_W(HCNT_W), .BW_W(HBW_W)) u_hscan (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce       (rd_ce),
        .hsync    (hsync),
        .pic_start(h_start),
        .pic_len  (h_len),
        .bw       (sh_hbw),
        .in_pic   (h_pic),
        .in_side  (h_side)
    );

    pip_vscan #(.CNT_W(VCNT_W), .BW_W(VBW_W), .LINE_W(LINE_W)) u_vscan (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce       (rd_ce),
        .hsync    (hsync),
        .vsync    (vsync),
        .dbl      (sh_dbl),
        .pic_start(v_start),
        .pic_len  (v_len),
        .bw       (sh_vbw),
        .in_pic   (v_pic),
        .in_band  (v_band),
        .line_idx (rd_line)
    );

    always_comb begin
        pic         = v_pic && h_pic;
        bord        = (v_band && (h_pic || h_side)) || (v_pic && h_side);
        pix_rd      = pic && rd_ce;
        border_flag = bord;
        bdr_y       = {bcolor[3*COMP_W-1:2*COMP_W], PAD_W'(0)};
        bdr_u       = {bcolor[2*COMP_W-1:COMP_W],   PAD_W'(0)};
        bdr_v       = {bcolor[COMP_W-1:0],          PAD_W'(0)};
    end

    pip_seldelay #(.DLY_W(DLY_W)) u_seldly (
        .clk  (clk),
        .rst_n(rst_n),
        .ce   (rd_ce),
        .raw  (pic || bord),
        .dly  (sel_dly),
        .sel  (sel_out)
    );

    assert_field_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ce && vsync) |=> (sh_hpos == $past(hpos) && sh_vpos == $past(vpos)));

    assert_strobe_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_ce) |-> !pix_rd);
endmodule

// File: tb/pip_overlay_timing_test.sv
module pip_overlay_timing_test;
    localparam int LINE_COLS = 316;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_ce = 1'b0, hsync = 1'b0, vsync = 1'b0;
    logic [9:0]  hpos = '0;
    logic [7:0]  vpos = '0;
    logic [2:0]  hbw = '0;
    logic [1:0]  vbw = '0;
    logic [11:0] bcolor = '0;
    logic        dbl_en = 1'b0, quarter = 1'b0, std625 = 1'b0;
    logic [3:0]  sel_dly = '0;
    logic        pix_rd, border_flag, sel_out;
    logic [6:0]  rd_line;
    logic [5:0]  bdr_y, bdr_u, bdr_v;

    int total = 0, bad = 0;
    bit finished = 0;

    int m_hpos = 0, m_vpos = 0, m_hbw = 0, m_vbw = 0;
    bit m_dbl = 0, m_q = 0, m_625 = 0;
    int bcol = 0, bline = 0;
    logic [15:0] ehist = '0;

    always #10 clk = ~clk;

    pip_overlay_timing uut (
        .clk(clk), .rst_n(rst_n), .rd_ce(rd_ce), .hsync(hsync), .vsync(vsync),
        .hpos(hpos), .vpos(vpos), .hbw(hbw), .vbw(vbw), .bcolor(bcolor),
        .dbl_en(dbl_en), .quarter(quarter), .std625(std625), .sel_dly(sel_dly),
        .pix_rd(pix_rd), .rd_line(rd_line), .border_flag(border_flag),
        .bdr_y(bdr_y), .bdr_u(bdr_u), .bdr_v(bdr_v), .sel_out(sel_out)
    );

    function automatic int vheight(bit q, bit s625, bit dbl);
        int b;
        if (q) b = s625 ? 66 : 57;
        else   b = s625 ? 88 : 76;
        return dbl ? 2 * b : b;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (col %0d line %0d)", tag, act, exp, bcol, bline);
        end
    endtask

    task automatic tick(input bit ce, input bit hs, input bit vs);
        int hs0, he, vs0, ve, idx;
        bit hp, hside, vp, vband, pic, bord;
        @(negedge clk);
        rd_ce = ce; hsync = hs; vsync = vs;
        #1;
        if (ce) begin
            hs0 = 54 + m_hpos;
            he  = hs0 + (m_q ? 160 : 212);
            vs0 = 4 + m_vpos;
            ve  = vs0 + vheight(m_q, m_625, m_dbl);
            hp    = (bcol >= hs0) && (bcol < he);
            hside = ((bcol >= hs0 - m_hbw) && (bcol < hs0)) || ((bcol >= he) && (bcol < he + m_hbw));
            vp    = (bline >= vs0) && (bline < ve);
            vband = ((bline >= vs0 - m_vbw) && (bline < vs0)) || ((bline >= ve) && (bline < ve + m_vbw));
            pic  = vp && hp;
            bord = (vband && (hp || hside)) || (vp && hside);
            chk(vp ? "R2 pixel strobe" : "R3 pixel strobe", int'(pix_rd), int'(pic));
            chk(vband ? "R5 border flag" : "R4 border flag", int'(border_flag), int'(bord));
            if (pic)
                chk(m_dbl ? "R7 line index" : "R8 line index", int'(rd_line),
                    m_dbl ? (bline - vs0) / 2 : bline - vs0);
            ehist = {ehist[14:0], pic | bord};
            idx = (int'($signed(sel_dly)) + 8);
            chk("R9 select", int'(sel_out), int'(ehist[idx]));
        end else begin
            chk("R11 strobe gated", int'(pix_rd), 0);
        end
        if (ce) begin
            if (vs) begin
                m_hpos = hpos; m_vpos = vpos; m_hbw = hbw; m_vbw = vbw;
                m_dbl = dbl_en; m_q = quarter; m_625 = std625;
                bline = 0;
            end else if (hs) begin
                bline++;
            end
            if (hs) bcol = 0; else bcol++;
        end
    endtask

    task automatic run_line(input bit vs, input bit rnd);
        int n = 0;
        tick(1'b1, 1'b1, vs);
        while (n < LINE_COLS - 1) begin
            bit c;
            c = rnd ? ($urandom % 4 != 0) : 1'b1;
            tick(c, 1'b0, 1'b0);
            if (c) n++;
        end
    endtask

    task automatic run_field(input bit rnd, input bit change_mid);
        int lines;
        lines = 4 + vpos + vheight(quarter, std625, dbl_en) + vbw + 2;
        run_line(1'b1, rnd);
        if (change_mid) begin
            hpos = 10'(2 + $urandom % 39);
            vpos = 8'($urandom % 13);
            hbw  = 3'($urandom % 8);
            vbw  = 2'($urandom % 4);
        end
        for (int i = 1; i < lines; i++) run_line(1'b0, rnd);
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk("R1 reset pix_rd", int'(pix_rd), 0);
        chk("R1 reset border", int'(border_flag), 0);
        chk("R1 reset select", int'(sel_out), 0);
        chk("R1 reset line", int'(rd_line), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) tick(1'b1, 1'b0, 1'b0);

        // R6: colour expansion
        for (int i = 0; i < 6; i++) begin
            bcolor = (i == 0) ? 12'hFFF : (i == 1) ? 12'h000 : 12'($urandom);
            #2;
            chk("R6 border Y", int'(bdr_y), int'({bcolor[11:8], 2'b00}));
            chk("R6 border U", int'(bdr_u), int'({bcolor[7:4], 2'b00}));
            chk("R6 border V", int'(bdr_v), int'({bcolor[3:0], 2'b00}));
        end

        // field 1: large picture, 625, maximum borders, minimum position, earliest select
        hpos = 10'd2; vpos = 8'($urandom % 13); hbw = 3'd7; vbw = 2'd3;
        quarter = 1'b0; std625 = 1'b1; dbl_en = 1'b0; sel_dly = 4'h8;
        run_field(1'b0, 1'b0);

        // field 2: small picture, 525, line doubling, random geometry
        hpos = 10'(2 + $urandom % 39); vpos = 8'($urandom % 13);
        hbw = 3'($urandom % 8); vbw = 2'($urandom % 4);
        quarter = 1'b1; std625 = 1'b0; dbl_en = 1'b1; sel_dly = 4'($urandom);
        run_field(1'b0, 1'b0);

        // field 3: small picture, 625, no border, gapped enable, R10 mid-field change
        hpos = 10'd40; vpos = 8'd3; hbw = 3'd0; vbw = 2'd0;
        quarter = 1'b1; std625 = 1'b1; dbl_en = 1'b0; sel_dly = 4'h0;
        run_field(1'b1, 1'b1);

        // field 4: large picture, 525, latest select
        hpos = 10'(2 + $urandom % 39); vpos = 8'($urandom % 13);
        hbw = 3'($urandom % 8); vbw = 2'($urandom % 4);
        quarter = 1'b0; std625 = 1'b0; dbl_en = 1'b0; sel_dly = 4'h7;
        run_field(1'b0, 1'b0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule